// File: doc/BRIEF.md
# Bridge Fault Diagnosis and Error Encoder

This block watches digitized fault events from two full bridges that drive a bipolar stepper motor and condenses them into a single two-bit error code. For each bridge it takes the turn-on instant of the sink switch, a sink overcurrent at the short level, the normal chopper comparator trip, a source overload, a polarity reversal, a detected flyback pulse and the low-current flag. It also takes a chip-wide thermal pre-alarm and thermal shutdown, a pulse that marks each new accepted command frame, and a standby request.

Short to supply is recognised only inside a timed window after each sink turn-on. Repeated shorts are counted, and once the retry budget is spent the sink is forced off until the next frame. A source overload turns off its bridge until the next frame. A missing flyback after a polarity reversal marks an open load, but this is reported only after a settling filter has counted enough chopper trips. The per-bridge codes are merged by priority. Thermal events give 00, short to ground gives 10, the open-load and short-to-supply class gives 01, and the fault-free code is 11. Within a class the codes of both bridges are combined by AND.

Top module: `bridge_fault_diag`

## Requirements
- R1: A sink overcurrent is ignored in the turn-on cycle and at ages 1 to BLANK_CYC-1 cycles after it. It is also ignored at age WIN_END or later. The error code stays 11.
- R2: A sink overcurrent at an age from BLANK_CYC to WIN_END-1 marks a short to supply. The error code becomes 01 from the next cycle.
- R3: Once SHORT_LIMIT detections have accumulated on a bridge, its `sink_force_off` bit goes high. A frame pulse clears the count and drops the bit.
- R4: A normal chopper trip on a bridge clears that bridge's short-to-supply mark.
- R5: A source overload sets the bridge's `bridge_off` bit and gives code 10. Both stay until a frame pulse arrives.
- R6: After a reversal, if no flyback arrives within FLY_WIN cycles, an open load is marked (code 01). A flyback inside the window clears the mark.
- R7: A reversal made while `low_cur` is high starts no flyback check.
- R8: An open-load mark stays hidden until SETTLE_PULSES chopper trips have been seen on that bridge since reset or standby.
- R9: A short to ground on either bridge outranks the 01 class, giving code 10. Codes in the same class from both bridges AND together.
- R10: The thermal pre-alarm forces code 00. Thermal shutdown forces code 00, raises both `bridge_off` bits and raises `report_ones`.
- R11: Standby clears every mark, count and filter. Code 11 follows unless a thermal input is active.
- R12: After reset the code is 11 and `sink_force_off`, `bridge_off` and `report_ones` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Synchronous clear of all diagnosis state |
| telegram | input | 1 | Pulse marking a newly accepted command frame |
| therm_alarm | input | 1 | Thermal pre-alarm |
| therm_shdn | input | 1 | Thermal shutdown |
| sink_on | input | NB | Sink switch turn-on pulse per bridge |
| sink_oc | input | NB | Sink current above 1.5x full scale per bridge |
| pwm_trip | input | NB | Normal chopper comparator trip per bridge |
| src_ovl | input | NB | Source switch overload per bridge |
| phase_rev | input | NB | Polarity reversal pulse per bridge |
| low_cur | input | NB | Bridge runs in the low-current setting |
| flyback | input | NB | Flyback pulse seen per bridge |
| err_code | output | 2 | Merged error code, 11 means no fault |
| sink_force_off | output | NB | Hold sink off after the short retry budget is spent |
| bridge_off | output | NB | Turn the bridge off (overload or shutdown) |
| report_ones | output | 1 | Report the setting bits as all ones |

## Verification
Overcurrent pulses are placed at ages just inside and just outside the detection window. This separates blanking from real detection and from a window that never closes. Reversals are driven with a flyback, without one, and in the low-current setting, both before and after the settling filter has filled, so a hidden mark can be told apart from an absent one. Mixed faults are then stacked on the two bridges and under thermal inputs to expose the priority order and the same-class merge. A behavioural model in the bench follows every cycle, so a glitch between the deliberate checks is also caught.

// File: rtl/bridge_fault_diag.sv
module bridge_fault_diag #(
  parameter int NB            = 2,
  parameter int BLANK_CYC     = 3,
  parameter int WIN_END       = 8,
  parameter int SHORT_LIMIT   = 8,
  parameter int FLY_WIN       = 6,
  parameter int SETTLE_PULSES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          standby,
  input  logic          telegram,
  input  logic          therm_alarm,
  input  logic          therm_shdn,
  input  logic [NB-1:0] sink_on,
  input  logic [NB-1:0] sink_oc,
  input  logic [NB-1:0] pwm_trip,
  input  logic [NB-1:0] src_ovl,
  input  logic [NB-1:0] phase_rev,
  input  logic [NB-1:0] low_cur,
  input  logic [NB-1:0] flyback,
  output logic [1:0]    err_code,
  output logic [NB-1:0] sink_force_off,
  output logic [NB-1:0] bridge_off,
  output logic          report_ones
);
  localparam int AW = $clog2(WIN_END + 1);
  localparam int SW = $clog2(SHORT_LIMIT + 1);
  localparam int FW = $clog2(FLY_WIN + 1);
  localparam int TW = $clog2(SETTLE_PULSES + 1);

  logic [NB-1:0] gnd_cls, sup_cls;

  for (genvar i = 0; i < NB; i++) begin : g_br
    logic [AW-1:0] age;
    logic [SW-1:0] scnt;
    logic [FW-1:0] wc;
    logic [TW-1:0] stl;
    logic act, det, sflag, ovl, watch, open_q;

    assign det = act && !sink_on[i] && sink_oc[i] && (age >= AW'(BLANK_CYC));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        age <= '0; act <= 1'b0; scnt <= '0; sflag <= 1'b0; ovl <= 1'b0;
        watch <= 1'b0; wc <= '0; open_q <= 1'b0; stl <= '0;
      end else if (standby) begin
        age <= '0; act <= 1'b0; scnt <= '0; sflag <= 1'b0; ovl <= 1'b0;
        watch <= 1'b0; wc <= '0; open_q <= 1'b0; stl <= '0;
      end else begin
        if (sink_on[i]) begin
          age <= AW'(1);
          act <= 1'b1;
        end else if (act) begin
          age <= age + AW'(1);
          act <= (age + AW'(1)) < AW'(WIN_END);
        end

        if (telegram)
          scnt <= det ? SW'(1) : '0;
        else if (det && scnt < SW'(SHORT_LIMIT))
          scnt <= scnt + SW'(1);

        if (det)              sflag <= 1'b1;
        else if (pwm_trip[i]) sflag <= 1'b0;

        if (src_ovl[i])    ovl <= 1'b1;
        else if (telegram) ovl <= 1'b0;

        if (pwm_trip[i] && stl < TW'(SETTLE_PULSES))
          stl <= stl + TW'(1);

        if (phase_rev[i] && !low_cur[i]) begin
          watch <= 1'b1;
          wc    <= FW'(1);
        end else if (watch) begin
          if (flyback[i]) begin
            watch  <= 1'b0;
            open_q <= 1'b0;
          end else if (wc == FW'(FLY_WIN)) begin
            watch  <= 1'b0;
            open_q <= 1'b1;
          end else begin
            wc <= wc + FW'(1);
          end
        end
      end
    end

    assign gnd_cls[i]        = ovl;
    assign sup_cls[i]        = sflag || (open_q && stl == TW'(SETTLE_PULSES));
    assign sink_force_off[i] = scnt == SW'(SHORT_LIMIT);
    assign bridge_off[i]     = ovl || therm_shdn;
  end

  assign err_code    = (therm_alarm || therm_shdn) ? 2'b00 :
                       (|gnd_cls)                  ? 2'b10 :
                       (|sup_cls)                  ? 2'b01 : 2'b11;
  assign report_ones = therm_shdn;
endmodule

// File: rtl/bridge_fault_diag_chk.sv
module bridge_fault_diag_chk #(
  parameter int NB = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          standby,
  input logic          telegram,
  input logic          therm_alarm,
  input logic          therm_shdn,
  input logic [NB-1:0] sink_oc,
  input logic [NB-1:0] src_ovl,
  input logic [1:0]    err_code,
  input logic [NB-1:0] sink_force_off,
  input logic [NB-1:0] bridge_off,
  input logic          report_ones
);
  assert_shdn_report_R10: assert property (@(posedge clk) disable iff (!rst_n)
    therm_shdn |-> (err_code == 2'b00) && (&bridge_off) && report_ones);

  assert_alarm_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    therm_alarm |-> err_code == 2'b00);

  assert_gnd_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|bridge_off) && !therm_shdn && !therm_alarm) |-> err_code == 2'b10);

  assert_standby_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (sink_force_off == '0) &&
                (err_code == 2'b11 || therm_alarm || therm_shdn));

  for (genvar i = 0; i < NB; i++) begin : g_chk
    assert_ovl_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (src_ovl[i] && !standby) |=> bridge_off[i]);

    assert_force_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      telegram |=> !sink_force_off[i]);

    assert_force_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sink_force_off[i]) |-> $past(sink_oc[i]));
  end
endmodule

bind bridge_fault_diag bridge_fault_diag_chk #(.NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby), .telegram(telegram),
  .therm_alarm(therm_alarm), .therm_shdn(therm_shdn), .sink_oc(sink_oc),
  .src_ovl(src_ovl), .err_code(err_code), .sink_force_off(sink_force_off),
  .bridge_off(bridge_off), .report_ones(report_ones)
);

// File: tb/test_bridge_fault_diag.sv
module test_bridge_fault_diag;
  localparam int NB = 2, BLANK = 3, WEND = 8, LIM = 8, FLY = 6, SETL = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic standby = 0, telegram = 0, therm_alarm = 0, therm_shdn = 0;
  logic [NB-1:0] sink_on = 0, sink_oc = 0, pwm_trip = 0, src_ovl = 0;
  logic [NB-1:0] phase_rev = 0, low_cur = 0, flyback = 0;
  logic [1:0] err_code;
  logic [NB-1:0] sink_force_off, bridge_off;
  logic report_ones;

  int checks = 0, failures = 0, cycles = 0;
  string cur_req = "R12";

  always #10 clk = ~clk;

  bridge_fault_diag #(.NB(NB), .BLANK_CYC(BLANK), .WIN_END(WEND), .SHORT_LIMIT(LIM),
    .FLY_WIN(FLY), .SETTLE_PULSES(SETL)) i_bridge_fault_diag (
    .clk(clk), .rst_n(rst_n), .standby(standby), .telegram(telegram),
    .therm_alarm(therm_alarm), .therm_shdn(therm_shdn), .sink_on(sink_on),
    .sink_oc(sink_oc), .pwm_trip(pwm_trip), .src_ovl(src_ovl),
    .phase_rev(phase_rev), .low_cur(low_cur), .flyback(flyback),
    .err_code(err_code), .sink_force_off(sink_force_off),
    .bridge_off(bridge_off), .report_ones(report_ones));

  // behavioural reference model
  int m_age[NB], m_scnt[NB], m_wc[NB], m_stl[NB];
  bit m_sh[NB], m_ovl[NB], m_watch[NB], m_open[NB];

  task automatic m_clear();
    for (int b = 0; b < NB; b++) begin
      m_age[b] = 1000; m_scnt[b] = 0; m_wc[b] = 0; m_stl[b] = 0;
      m_sh[b] = 0; m_ovl[b] = 0; m_watch[b] = 0; m_open[b] = 0;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n || standby) m_clear();
    else for (int b = 0; b < NB; b++) begin
      int a;
      bit hit;
      a = sink_on[b] ? 0 : m_age[b];
      hit = sink_oc[b] && a >= BLANK && a < WEND;
      m_age[b] = (a < 1000) ? a + 1 : 1000;
      if (telegram) m_scnt[b] = hit ? 1 : 0;
      else if (hit && m_scnt[b] < LIM) m_scnt[b]++;
      if (hit) m_sh[b] = 1; else if (pwm_trip[b]) m_sh[b] = 0;
      if (src_ovl[b]) m_ovl[b] = 1; else if (telegram) m_ovl[b] = 0;
      if (pwm_trip[b] && m_stl[b] < SETL) m_stl[b]++;
      if (phase_rev[b] && !low_cur[b]) begin m_watch[b] = 1; m_wc[b] = 1; end
      else if (m_watch[b]) begin
        if (flyback[b]) begin m_watch[b] = 0; m_open[b] = 0; end
        else if (m_wc[b] == FLY) begin m_watch[b] = 0; m_open[b] = 1; end
        else m_wc[b]++;
      end
    end
  end

  function automatic logic [1:0] m_err();
    bit g = 0, s = 0;
    if (therm_alarm || therm_shdn) return 2'b00;
    for (int b = 0; b < NB; b++) begin
      g |= m_ovl[b];
      s |= m_sh[b] || (m_open[b] && m_stl[b] == SETL);
    end
    return g ? 2'b10 : s ? 2'b01 : 2'b11;
  endfunction

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      logic [NB-1:0] fo, bo;
      for (int b = 0; b < NB; b++) begin
        fo[b] = m_scnt[b] == LIM;
        bo[b] = m_ovl[b] || therm_shdn;
      end
      checks++;
      if (err_code !== m_err() || sink_force_off !== fo || bridge_off !== bo ||
          report_ones !== therm_shdn) begin
        failures++;
        $display("FAIL %s model: err=%b/%b force=%b/%b off=%b/%b ones=%b/%b", cur_req,
                 err_code, m_err(), sink_force_off, fo, bridge_off, bo, report_ones, therm_shdn);
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(logic [1:0] exp_err, logic [NB-1:0] exp_fo, logic [NB-1:0] exp_bo,
                     string req);
    checks++;
    if (err_code !== exp_err || sink_force_off !== exp_fo || bridge_off !== exp_bo) begin
      failures++;
      $display("FAIL %s: err=%b exp %b force=%b exp %b off=%b exp %b", req,
               err_code, exp_err, sink_force_off, exp_fo, bridge_off, exp_bo);
    end
  endtask

  task automatic tg();
    telegram = 1; step(); telegram = 0;
  endtask

  task automatic short_at(int b, int age_cyc);
    sink_on[b] = 1; step(); sink_on[b] = 0;
    if (age_cyc > 1) step(age_cyc - 1);
    sink_oc[b] = 1; step(); sink_oc[b] = 0;
  endtask

  task automatic trips(int b, int n);
    repeat (n) begin pwm_trip[b] = 1; step(); pwm_trip[b] = 0; step(); end
  endtask

  task automatic rev(int b, int fly_age);
    phase_rev[b] = 1; step(); phase_rev[b] = 0;
    if (fly_age > 0) begin
      if (fly_age > 1) step(fly_age - 1);
      flyback[b] = 1; step(); flyback[b] = 0;
    end
    step(FLY + 2);
  endtask

  initial begin
    step(3); rst_n = 1; step();
    cur_req = "R12"; chk(2'b11, 2'b00, 2'b00, "R12");
    checks++;
    if (report_ones !== 1'b0) begin failures++; $display("FAIL R12: ones=%b exp 0", report_ones); end

    cur_req = "R1";
    short_at(0, 1); step(); chk(2'b11, 2'b00, 2'b00, "R1 age1");
    short_at(0, BLANK - 1); step(); chk(2'b11, 2'b00, 2'b00, "R1 age2");
    short_at(0, WEND); step(); chk(2'b11, 2'b00, 2'b00, "R1 age8");
    sink_on[0] = 1; sink_oc[0] = 1; step(); sink_on[0] = 0; sink_oc[0] = 0; step();
    chk(2'b11, 2'b00, 2'b00, "R1 age0");

    cur_req = "R2";
    short_at(0, BLANK); chk(2'b01, 2'b00, 2'b00, "R2 age3");
    cur_req = "R4";
    trips(0, 1); chk(2'b11, 2'b00, 2'b00, "R4");
    cur_req = "R2";
    short_at(1, WEND - 1); chk(2'b01, 2'b00, 2'b00, "R2 age7");
    trips(1, 1);

    cur_req = "R3";
    tg();
    repeat (LIM - 1) short_at(0, 4);
    chk(2'b01, 2'b00, 2'b00, "R3 seven");
    short_at(0, 4); chk(2'b01, 2'b01, 2'b00, "R3 eight");
    tg(); chk(2'b01, 2'b00, 2'b00, "R3 frame");
    trips(0, 1);

    cur_req = "R5";
    src_ovl[1] = 1; step(); src_ovl[1] = 0; step(4);
    chk(2'b10, 2'b00, 2'b10, "R5 hold");
    tg(); chk(2'b11, 2'b00, 2'b00, "R5 frame");

    cur_req = "R8";
    standby = 1; step(); standby = 0; step();
    trips(0, SETL - 1);
    rev(0, 0); chk(2'b11, 2'b00, 2'b00, "R8 hidden");
    trips(0, 1); chk(2'b01, 2'b00, 2'b00, "R8 settled");

    cur_req = "R6";
    rev(0, 2); chk(2'b11, 2'b00, 2'b00, "R6 flyback");
    rev(0, FLY); chk(2'b11, 2'b00, 2'b00, "R6 last");
    rev(0, 0); chk(2'b01, 2'b00, 2'b00, "R6 open");
    rev(0, 1);

    cur_req = "R7";
    low_cur[0] = 1; rev(0, 0); low_cur[0] = 0;
    chk(2'b11, 2'b00, 2'b00, "R7");

    cur_req = "R9";
    short_at(0, 4); src_ovl[1] = 1; step(); src_ovl[1] = 0; step();
    chk(2'b10, 2'b00, 2'b10, "R9 gnd wins");
    short_at(1, 5); tg(); chk(2'b01, 2'b00, 2'b00, "R9 same class");
    trips(0, 1); chk(2'b01, 2'b00, 2'b00, "R9 one left");
    trips(1, 1); chk(2'b11, 2'b00, 2'b00, "R9 clear");

    cur_req = "R10";
    src_ovl[0] = 1; step(); src_ovl[0] = 0;
    therm_alarm = 1; step(); chk(2'b00, 2'b00, 2'b01, "R10 alarm");
    therm_alarm = 0; therm_shdn = 1; step();
    chk(2'b00, 2'b00, 2'b11, "R10 shdn");
    checks++;
    if (report_ones !== 1'b1) begin failures++; $display("FAIL R10: ones=%b exp 1", report_ones); end
    therm_shdn = 0; step();

    cur_req = "R11";
    repeat (LIM) short_at(1, 4);
    chk(2'b10, 2'b10, 2'b01, "R11 before");
    standby = 1; step(); standby = 0; step();
    chk(2'b11, 2'b00, 2'b00, "R11 after");

    step(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog: cycles=%0d exp <= 100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule